// File: doc/BRIEF.md
# Nonce-Seeded Cascade Cipher Sequencer

This block drives a lightweight hybrid cipher that works on 16-bit words. Its secret state has 80 bits: four 16-bit chaining registers and a 16-bit LFSR. The 256-bit key is cut into four 64-bit subkeys, one for each of four keyed 16-bit permutations. These permutations are chained, and modular addition (for encryption) or modular subtraction (for decryption) joins each one to the chaining registers.

A nonce load fills the chaining registers and starts a fixed initialization of four cascade passes. That initialization yields the LFSR seed. After it, each start strobe enciphers or deciphers one word. Every word advances the chaining registers and the LFSR, so repeated plaintexts give different ciphertexts. A receiver that loads the same key and nonce and then deciphers the same word sequence recovers the plaintexts.

The datapath has one forward permutation and one inverse permutation. Each is used once per cycle, so a word takes four cycles and the initialization takes sixteen.

Top module: `lwc_cascade`

## Requirements
- R1: After reset, `done` is 0 and `dout` is 0. A `start` pulse is ignored until an initialization has completed since the last nonce load: no `done` pulse follows and `dout` stays 0.
- R2: `nonce_ld` is accepted only while the block is idle. Chaining register k (k = 1..4) takes `nonce[16k-1 -: 16]`, and any earlier initialization is cancelled. Four forward cascade passes follow. The input of the first pass is RS1 + RS3. After each pass: RS1 += V34, RS3 += V23, RS4 += V12, RS2 += TV, where TV is the stage-4 output. `done` pulses 16 cycles after the load edge, and `dout` is unchanged.
- R3: The keyed permutation applies four rounds and then a final step. A round computes x = L(S(x ^ rk_r)) for r = 0..3, where rk_r = subkey[16r +: 16]. The final step computes x = S(x ^ rk_0 ^ rk_2) ^ rk_1 ^ rk_3. L(x) = x ^ (x << 6) ^ (x << 10), with the shifts truncated to 16 bits. S applies four 4-bit S-boxes. The S-box on bits [15:12] uses table 865F1CA9EB2470D3, the one on [11:8] uses 07E15B823AD6FC49, the one on [7:4] uses 2EF5C19AB468073D, and the one on [3:0] uses 0734C1AFDE6B2895. In each table the leftmost hex digit is the image of input 0. Stage j uses subkey `key[64(j-1) +: 64]`.
- R4: Encryption (`decrypt`=0) computes V12 = E1(P + RS1), V23 = E2(V12 + RS2), V34 = E3(V23 + RS3), and C = E4(V34 + RS4). All sums are taken modulo 2^16.
- R5: Decryption (`decrypt`=1) computes V34 = D4(C) − RS4, V23 = D3(V34) − RS3, V12 = D2(V23) − RS2, and P = D1(V12) − RS1, where Dj is the inverse of Ej. A ciphertext sequence deciphered after the same key and nonce returns the original plaintexts.
- R6: After each word, and only after all four stages, the chaining registers are updated in this order: RS1 += V34; RS3 += V23 + LFSR, using the LFSR value before its step; RS4 += V12 + RS1new; RS2 += V12 + RS4new.
- R7: At the end of initialization the LFSR is loaded with TV | 0x1000. Each word then steps it once, to {l[14:0], l[15]^l[14]^l[11]^l[9]^l[6]^l[2]}.
- R8: For a word, `done` is high for exactly one cycle, 4 cycles after the edge that accepts `start`, and `dout` presents the result in that same cycle. `dout` changes only when `done` is high.
- R9: While a word or the initialization is in progress, `start` and `nonce_ld` are ignored. They disturb neither the result nor the later chaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key | input | 256 | Secret key, held stable during operation |
| nonce_ld | input | 1 | Load the nonce and run the initialization |
| nonce | input | 64 | Four 16-bit chaining-register seeds |
| start | input | 1 | Process one word |
| decrypt | input | 1 | Mode with `start`: 0 encrypt, 1 decrypt |
| din | input | 16 | Word to process, sampled with `start` |
| dout | output | 16 | Result word |
| done | output | 1 | One-cycle completion pulse |

## Verification
A word result appears on `dout` with `done` four cycles after the accepting edge. The initialization pulse comes sixteen cycles after the load edge. The bench samples at the falling edge after each of those edges and checks that `done` is low at every earlier falling edge. Stray `start` and `nonce_ld` pulses are placed inside these windows. Their absence of effect then appears at the ports: the next result stays correct and the ciphertext chain stays intact. Long encrypt and decrypt sweeps with mixed modes compare every word against an arithmetic model of the cascade kept in the bench.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned NSTAGE  = 4;
  localparam int unsigned NROUND  = 4;
  localparam int unsigned SUBK_W  = WORD_W * NROUND;
  localparam int unsigned KEY_W   = SUBK_W * NSTAGE;
  localparam int unsigned NIB     = WORD_W / 4;
  localparam int unsigned SHIFT_A = 6;
  localparam int unsigned SHIFT_B = 10;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_WORD} seq_st_t;

  localparam logic [63:0] SBOX_TBL [NIB] = '{
    64'h865F1CA9EB2470D3,
    64'h07E15B823AD6FC49,
    64'h2EF5C19AB468073D,
    64'h0734C1AFDE6B2895
  };

  function automatic logic [3:0] sbox_map(input int unsigned t, input logic [3:0] v);
    int unsigned sh;
    sh = 60 - 4 * int'(v);
    return 4'(SBOX_TBL[t] >> sh);
  endfunction

  function automatic logic [3:0] sbox_unmap(input int unsigned t, input logic [3:0] v);
    logic [3:0] r;
    r = '0;
    for (int j = 0; j < 16; j++) begin
      if (sbox_map(t, 4'(j)) == v) r = 4'(j);
    end
    return r;
  endfunction

  function automatic word_t sub_fwd(input word_t x);
    word_t y;
    for (int n = 0; n < NIB; n++) y[WORD_W-1-4*n -: 4] = sbox_map(n, x[WORD_W-1-4*n -: 4]);
    return y;
  endfunction

  function automatic word_t sub_inv(input word_t x);
    word_t y;
    for (int n = 0; n < NIB; n++) y[WORD_W-1-4*n -: 4] = sbox_unmap(n, x[WORD_W-1-4*n -: 4]);
    return y;
  endfunction

  function automatic word_t lin_fwd(input word_t x);
    return x ^ (x << SHIFT_A) ^ (x << SHIFT_B);
  endfunction

  // Lower-triangular map: recover bits from LSB upward.
  function automatic word_t lin_inv(input word_t x);
    word_t y;
    y = '0;
    for (int i = 0; i < WORD_W; i++) begin
      logic b;
      b = x[i];
      if (i >= SHIFT_A) b = b ^ y[i-SHIFT_A];
      if (i >= SHIFT_B) b = b ^ y[i-SHIFT_B];
      y[i] = b;
    end
    return y;
  endfunction
endpackage

// File: rtl/lwc_rst_sync.sv
module lwc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lwc_perm.sv
module lwc_perm
  import lwc_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [SUBK_W-1:0] subkey,
  input  word_t             din,
  output word_t             dout
);
  word_t rk [NROUND];

  for (genvar r = 0; r < NROUND; r++) begin : g_rk
    assign rk[r] = subkey[WORD_W*r +: WORD_W];
  end

  if (INVERSE) begin : g_inv
    always_comb begin
      word_t x;
      x = din ^ rk[1] ^ rk[3];
      x = sub_inv(x) ^ rk[0] ^ rk[2];
      for (int r = NROUND-1; r >= 0; r--) x = sub_inv(lin_inv(x)) ^ rk[r];
      dout = x;
    end
  end else begin : g_fwd
    always_comb begin
      word_t x;
      x = din;
      for (int r = 0; r < NROUND; r++) x = lin_fwd(sub_fwd(x ^ rk[r]));
      dout = sub_fwd(x ^ rk[0] ^ rk[2]) ^ rk[1] ^ rk[3];
    end
  end
endmodule

// File: rtl/lwc_lfsr.sv
module lwc_lfsr
  import lwc_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  logic  seed_ld,
  input  word_t seed,
  input  logic  step,
  output word_t value
);
  word_t q, d;

  always_comb begin
    d = q;
    if (seed_ld)   d = seed;
    else if (step) d = {q[14:0], q[15] ^ q[14] ^ q[11] ^ q[9] ^ q[6] ^ q[2]};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)              q <= '0;
    else if (seed_ld || step) q <= d;
  end

  assign value = q;
endmodule

// File: rtl/lwc_cascade.sv
module lwc_cascade
  import lwc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [255:0] key,
  input  logic         nonce_ld,
  input  logic [63:0]  nonce,
  input  logic         start,
  input  logic         decrypt,
  input  logic [15:0]  din,
  output logic [15:0]  dout,
  output logic         done
);
  localparam int unsigned SW = $clog2(NSTAGE);
  localparam logic [SW-1:0] LAST = SW'(NSTAGE - 1);
  localparam word_t SEED_FORCE = word_t'(1) << 12;

  logic srst_n;
  seq_st_t st_q, st_d;
  logic [SW-1:0] stage_q, stage_d, run_q, run_d, fidx, iidx, vidx;
  logic dec_q, dec_d, inited_q, inited_d, done_q, done_d;
  word_t x_q, x_d, dout_q, dout_d;
  word_t rs_q [NSTAGE];
  word_t rs_d [NSTAGE];
  word_t v_q [NSTAGE-1];
  word_t v_d [NSTAGE-1];
  word_t fwd_in, fwd_out, inv_out, inv_res, stage_res, lfsr_val;
  word_t u1, u2, u3, u4;
  logic lfsr_ld, lfsr_step, last;

  lwc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign fidx    = stage_q;
  assign iidx    = LAST - stage_q;
  assign vidx    = dec_q ? (SW'(NSTAGE - 2) - stage_q) : stage_q;
  assign last    = (stage_q == LAST);
  assign fwd_in  = x_q + rs_q[fidx];
  assign inv_res = inv_out - rs_q[iidx];

  lwc_perm #(.INVERSE(1'b0)) u_fwd (
    .subkey(key[SUBK_W*fidx +: SUBK_W]), .din(fwd_in), .dout(fwd_out));

  lwc_perm #(.INVERSE(1'b1)) u_inv (
    .subkey(key[SUBK_W*iidx +: SUBK_W]), .din(x_q), .dout(inv_out));

  lwc_lfsr u_lfsr (
    .clk(clk), .srst_n(srst_n), .seed_ld(lfsr_ld), .seed(stage_res | SEED_FORCE),
    .step(lfsr_step), .value(lfsr_val));

  assign stage_res = (st_q == ST_WORD && dec_q) ? inv_res : fwd_out;

  // Chaining update candidates (V12 = v_q[0], V23 = v_q[1], V34 = v_q[2]).
  always_comb begin
    u1 = rs_q[0] + v_q[2];
    if (st_q == ST_INIT) begin
      u3 = rs_q[2] + v_q[1];
      u4 = rs_q[3] + v_q[0];
      u2 = rs_q[1] + stage_res;
    end else begin
      u3 = rs_q[2] + v_q[1] + lfsr_val;
      u4 = rs_q[3] + v_q[0] + u1;
      u2 = rs_q[1] + v_q[0] + u4;
    end
  end

  always_comb begin
    st_d      = st_q;
    stage_d   = stage_q;
    run_d     = run_q;
    dec_d     = dec_q;
    inited_d  = inited_q;
    x_d       = x_q;
    rs_d      = rs_q;
    v_d       = v_q;
    dout_d    = dout_q;
    done_d    = 1'b0;
    lfsr_ld   = 1'b0;
    lfsr_step = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (nonce_ld) begin
          for (int k = 0; k < NSTAGE; k++) rs_d[k] = nonce[WORD_W*k +: WORD_W];
          x_d      = nonce[WORD_W*2 +: WORD_W];
          stage_d  = '0;
          run_d    = '0;
          inited_d = 1'b0;
          st_d     = ST_INIT;
        end else if (start && inited_q) begin
          x_d     = din;
          dec_d   = decrypt;
          stage_d = '0;
          st_d    = ST_WORD;
        end
      end
      ST_INIT: begin
        x_d     = stage_res;
        stage_d = stage_q + 1'b1;
        if (!last) begin
          v_d[stage_q] = stage_res;
        end else begin
          rs_d[0] = u1;
          rs_d[1] = u2;
          rs_d[2] = u3;
          rs_d[3] = u4;
          x_d     = u3;
          run_d   = run_q + 1'b1;
          if (run_q == LAST) begin
            st_d     = ST_IDLE;
            inited_d = 1'b1;
            lfsr_ld  = 1'b1;
            done_d   = 1'b1;
          end
        end
      end
      ST_WORD: begin
        x_d     = stage_res;
        stage_d = stage_q + 1'b1;
        if (!last) begin
          v_d[vidx] = stage_res;
        end else begin
          rs_d[0]   = u1;
          rs_d[1]   = u2;
          rs_d[2]   = u3;
          rs_d[3]   = u4;
          dout_d    = stage_res;
          done_d    = 1'b1;
          lfsr_step = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= ST_IDLE;
      stage_q  <= '0;
      run_q    <= '0;
      dec_q    <= 1'b0;
      inited_q <= 1'b0;
      x_q      <= '0;
      dout_q   <= '0;
      done_q   <= 1'b0;
      for (int k = 0; k < NSTAGE; k++) rs_q[k] <= '0;
      for (int k = 0; k < NSTAGE-1; k++) v_q[k] <= '0;
    end else begin
      st_q     <= st_d;
      stage_q  <= stage_d;
      run_q    <= run_d;
      dec_q    <= dec_d;
      inited_q <= inited_d;
      x_q      <= x_d;
      dout_q   <= dout_d;
      done_q   <= done_d;
      rs_q     <= rs_d;
      v_q      <= v_d;
    end
  end

  assign dout = dout_q;
  assign done = done_q;
endmodule

// File: rtl/lwc_cascade_chk.sv
module lwc_cascade_chk
  import lwc_pkg::*;
(
  input logic        clk,
  input logic        srst_n,
  input seq_st_t     st_q,
  input logic        inited_q,
  input logic [15:0] lfsr_val,
  input logic [15:0] dout,
  input logic        done
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !done |-> $stable(dout));

  // R9
  done_after_work_chk: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> ($past(st_q) != ST_IDLE) && (st_q == ST_IDLE));

  // R1
  word_needs_init_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_WORD) |-> inited_q);

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    inited_q |-> (lfsr_val != 16'h0000));
endmodule

bind lwc_cascade lwc_cascade_chk u_chk (
  .clk(clk), .srst_n(srst_n), .st_q(st_q), .inited_q(inited_q),
  .lfsr_val(lfsr_val), .dout(dout), .done(done));

// File: tb/test_lwc_cascade.sv
module test_lwc_cascade;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] key;
  logic         nonce_ld, start, decrypt, done;
  logic [63:0]  nonce;
  logic [15:0]  din, dout;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  lwc_cascade i_lwc_cascade (.clk(clk), .rst_n(rst_n), .key(key), .nonce_ld(nonce_ld),
    .nonce(nonce), .start(start), .decrypt(decrypt), .din(din), .dout(dout), .done(done));

  // ---------------- reference model ----------------
  localparam logic [63:0] TBL [4] = '{64'h865F1CA9EB2470D3, 64'h07E15B823AD6FC49,
                                      64'h2EF5C19AB468073D, 64'h0734C1AFDE6B2895};
  logic [3:0]  sf [4][16];
  logic [3:0]  si [4][16];
  logic [15:0] m_rs [4];
  logic [15:0] m_lfsr;

  function automatic logic [15:0] b_sub(input logic [15:0] x, input bit inv);
    logic [15:0] y;
    for (int n = 0; n < 4; n++)
      y[15-4*n -: 4] = inv ? si[n][x[15-4*n -: 4]] : sf[n][x[15-4*n -: 4]];
    return y;
  endfunction

  function automatic logic [15:0] b_lin(input logic [15:0] x);
    return x ^ (x << 6) ^ (x << 10);
  endfunction

  function automatic logic [15:0] b_lin_inv(input logic [15:0] x);
    logic [15:0] y = x;
    for (int i = 0; i < 3; i++) y = x ^ (y << 6) ^ (y << 10);
    return y;
  endfunction

  function automatic logic [15:0] b_rk(input int s, input int r);
    return key[64*s + 16*r +: 16];
  endfunction

  function automatic logic [15:0] b_e(input int s, input logic [15:0] x);
    logic [15:0] y = x;
    for (int r = 0; r < 4; r++) y = b_lin(b_sub(y ^ b_rk(s, r), 1'b0));
    return b_sub(y ^ b_rk(s, 0) ^ b_rk(s, 2), 1'b0) ^ b_rk(s, 1) ^ b_rk(s, 3);
  endfunction

  function automatic logic [15:0] b_d(input int s, input logic [15:0] x);
    logic [15:0] y;
    y = b_sub(x ^ b_rk(s, 1) ^ b_rk(s, 3), 1'b1) ^ b_rk(s, 0) ^ b_rk(s, 2);
    for (int r = 3; r >= 0; r--) y = b_sub(b_lin_inv(y), 1'b1) ^ b_rk(s, r);
    return y;
  endfunction

  task automatic m_init(input logic [63:0] nv);
    logic [15:0] a, b, c, tv;
    for (int k = 0; k < 4; k++) m_rs[k] = nv[16*k +: 16];
    for (int p = 0; p < 4; p++) begin
      a  = b_e(0, m_rs[0] + m_rs[2]);
      b  = b_e(1, a + m_rs[1]);
      c  = b_e(2, b + m_rs[2]);
      tv = b_e(3, c + m_rs[3]);
      m_rs[0] += c;
      m_rs[2] += b;
      m_rs[3] += a;
      m_rs[1] += tv;
      if (p == 3) m_lfsr = tv | 16'h1000;
    end
  endtask

  task automatic m_word(input bit dec, input logic [15:0] d, output logic [15:0] o);
    logic [15:0] a, b, c;
    if (!dec) begin
      a = b_e(0, d + m_rs[0]);
      b = b_e(1, a + m_rs[1]);
      c = b_e(2, b + m_rs[2]);
      o = b_e(3, c + m_rs[3]);
    end else begin
      c = b_d(3, d) - m_rs[3];
      b = b_d(2, c) - m_rs[2];
      a = b_d(1, b) - m_rs[1];
      o = b_d(0, a) - m_rs[0];
    end
    m_rs[0] = m_rs[0] + c;
    m_rs[2] = m_rs[2] + b + m_lfsr;
    m_rs[3] = m_rs[3] + a + m_rs[0];
    m_rs[1] = m_rs[1] + a + m_rs[3];
    m_lfsr  = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[14] ^ m_lfsr[11] ^ m_lfsr[9] ^ m_lfsr[6] ^ m_lfsr[2]};
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_init(input logic [63:0] nv);
    logic [15:0] prev;
    prev = dout;
    @(negedge clk); nonce_ld = 1'b1; nonce = nv;
    @(negedge clk); nonce_ld = 1'b0;
    m_init(nv);
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (i == 3) begin start = 1'b1; din = 16'hBEEF; end    // R9 stray start
      if (i == 4) start = 1'b0;
      if (i == 6) begin nonce_ld = 1'b1; nonce = ~nv; end     // R9 stray load
      if (i == 7) nonce_ld = 1'b0;
      chk("R2 init done timing", {15'd0, done}, {15'd0, i == 16});
    end
    chk("R2 dout kept over init", dout, prev);
  endtask

  task automatic do_word(input bit dec, input logic [15:0] d, input bit poke, output logic [15:0] o);
    logic [15:0] exp;
    @(negedge clk);
    chk("R8 done low before start", {15'd0, done}, 16'd0);
    start = 1'b1; decrypt = dec; din = d;
    @(negedge clk); start = 1'b0;
    m_word(dec, d, exp);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (poke && i == 1) begin start = 1'b1; decrypt = ~dec; din = ~d; end  // R9
      if (poke && i == 2) begin start = 1'b0; nonce_ld = 1'b1; nonce = {4{d}}; end
      if (poke && i == 3) nonce_ld = 1'b0;
      chk("R8 done latency", {15'd0, done}, {15'd0, i == 4});
    end
    chk(dec ? "R5 R6 R7 R3 decrypt" : "R4 R6 R7 R3 encrypt", dout, exp);
    o = dout;
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  logic [15:0] pt [300];
  logic [15:0] ct [300];

  initial begin
    for (int t = 0; t < 4; t++)
      for (int v = 0; v < 16; v++) begin
        sf[t][v] = 4'(TBL[t] >> (60 - 4*v));
        si[t][sf[t][v]] = 4'(v);
      end
    key = {64'h8796A5B4C3D2E1F0, 64'h0F1E2D3C4B5A6978, 64'hFEDCBA9876543210, 64'h0123456789ABCDEF};
    rst_n = 1'b0; nonce_ld = 1'b0; nonce = '0; start = 1'b0; decrypt = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {15'd0, done}, 16'd0);
    chk("R1 reset dout", dout, 16'd0);

    // R1: start before any initialization has no effect
    start = 1'b1; din = 16'h1234;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1 start before init", {15'd0, done}, 16'd0);
    end
    chk("R1 dout untouched", dout, 16'd0);

    // Encrypt a chain, with stray strobes on some words
    do_init(64'h1357_9BDF_2468_ACE0);
    for (int w = 0; w < 300; w++) begin
      pt[w] = 16'(w * 16'h9E37 + 16'h0101);
      do_word(1'b0, pt[w], (w % 7) == 3, ct[w]);
    end

    // R5: same nonce, decipher the chain back
    do_init(64'h1357_9BDF_2468_ACE0);
    for (int w = 0; w < 300; w++) begin
      logic [15:0] back;
      do_word(1'b1, ct[w], (w % 11) == 5, back);
      chk("R5 round trip", back, pt[w]);
    end

    // Mixed-mode sweep under another nonce, plus extreme words
    do_init(64'h0000_FFFF_0000_0000);
    for (int w = 0; w < 512; w++) begin
      logic [15:0] o;
      do_word((w % 3) == 2, (w < 4) ? {16{w[0]}} : 16'(w * 16'h3B1), 1'b0, o);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule